// File: doc/BRIEF.md
# PHY Management Frame Master

This block lets software reach the registers of an external Ethernet PHY over the two-wire management bus. Software talks to it through two words on a simple register bus. The command word holds the target PHY address, the register number, a direction flag, a start/busy flag and a clock divider. The data word holds the value to write, or receives the value read back.

Setting the busy flag in the command word starts a clause-22 frame. The block builds the management clock from its own clock, using the divider taken from the command. It shifts out the preamble, start code, opcode, addresses and turnaround. It then either drives the 16 data bits or releases the line and collects the 16 bits the PHY returns. When the last bit has gone by, busy drops on its own. Software polls for that and, after a read, fetches the result from the data word. The data pin is bidirectional, so the block presents a separate output value and an output enable, and the pad logic combines them.

Top module: `mdio_master`

## Requirements
- R1: After reset, both the command word (offset 0x98) and the data word (offset 0x94) read 0, MDC is low and the MDIO output enable is low.
- R2: The command word reads back with the register number in bits 4:0, the PHY address in bits 12:8, the write flag in bit 16, busy in bit 17, the preamble flag in bit 18 and the divider in bits 23:20. All other bits read 0. The data word reads back its 16-bit value in bits 15:0, with bits 31:16 reading 0.
- R3: Writing the command word with bit 17 set starts a frame, and bit 17 reads 1 from the next cycle. Bit 17 reads 0 again once the frame is over, and at that point MDC is low and the output enable is low.
- R4: While a frame runs, MDC is high for divider+1 clocks and low for divider+1 clocks, so one MDC period is 2*(divider+1) clocks. MDC stays low when no frame is running.
- R5: A frame with bit 16 = 1 (write) puts 64 bits on MDIO, most significant bit first within each field. The order is 32 ones, start code 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10, then the 16 bits of the data word. The output enable is high for all 64 bits.
- R6: A frame with bit 16 = 0 (read) sends opcode 10. It deasserts the output enable from the first turnaround bit (bit 46 of the frame) to the end of the frame. It samples MDIO on the 16 rising MDC edges that follow and loads the result into the data word, MSB first.
- R7: MDIO output changes only on a falling MDC edge, or when the frame starts.
- R8: The output enable is never high when busy is clear.
- R9: While busy is set, writes to the command word and to the data word are ignored.
- R10: Writing the command word with bit 17 clear stores the fields and starts no frame: MDC stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO value seen at the pad |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The bench builds the block with its default widths: 5-bit addresses, 16-bit data and a 32-bit preamble, which gives a 64-bit frame. The divider is a run-time field, so the bench sweeps it over 0, 1, 2, 3 and 10. Divider 0 gives the tightest case, one-clock half periods, where the PHY model has only half a clock to set up read data before the sampling edge. Divider 10 gives the normal operating rate. Frames with all-ones and all-zeros address and data fields show that each field lands in its own bit positions.

// File: rtl/mdio_pkg.sv
// Package: field positions of the command word and fixed frame codes.
// Assumes a 32-bit register bus; positions are software-visible and fixed.
package mdio_pkg;
    localparam int CMD_REG_LSB  = 0;
    localparam int CMD_PHY_LSB  = 8;
    localparam int CMD_WR_BIT   = 16;
    localparam int CMD_BUSY_BIT = 17;
    localparam int CMD_PRE_BIT  = 18;
    localparam int CMD_DIV_LSB  = 20;

    localparam logic [1:0] FRM_START = 2'b01;
    localparam logic [1:0] FRM_OP_WR = 2'b01;
    localparam logic [1:0] FRM_OP_RD = 2'b10;
    localparam logic [1:0] FRM_TA_WR = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
// Management clock generator: divides clk by 2*(div+1) while run is high.
// Assumes div is held stable while run is high. MDC is forced low when idle.
// rise/fall are single-cycle strobes, valid in the cycle whose edge toggles mdc.
module mdio_clkgen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    // Half-period terminal count reached
    assign tick = run && (cnt == div);
    assign rise = tick && !mdc;
    assign fall = tick && mdc;

    // Half-period counter and MDC toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
// Frame serialiser: shifts a preloaded frame out MSB first, one bit per MDC period.
// It advances on MDC falling strobes and, for reads, captures data on rising strobes.
// Assumes start is only pulsed while idle and that the frame is valid on start.
module mdio_shifter #(
    parameter int FRAME_LEN = 64,
    parameter int DATA_W    = 16,
    parameter int TA_POS    = 46,
    localparam int IDX_W    = $clog2(FRAME_LEN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 is_read,
    input  logic [FRAME_LEN-1:0] frame,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 mdi,
    output logic                 mdo,
    output logic                 oe,
    output logic                 active,
    output logic                 done,
    output logic [DATA_W-1:0]    rd_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(FRAME_LEN - DATA_W);

    logic [FRAME_LEN-1:0] sh;
    logic [IDX_W-1:0]     idx;
    logic                 rd_mode;

    // Frame ends at the falling edge after the last bit
    assign done = active && fall && (idx == LAST_IDX);
    assign mdo  = active && sh[FRAME_LEN-1];
    // Release the line from the read turnaround onward
    assign oe   = active && !(rd_mode && (idx >= TA_IDX));

    // Bit position and shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            idx     <= '0;
            sh      <= '0;
            rd_mode <= 1'b0;
        end else if (start && !active) begin
            active  <= 1'b1;
            idx     <= '0;
            sh      <= frame;
            rd_mode <= is_read;
        end else if (active && fall) begin
            if (idx == LAST_IDX) begin
                active <= 1'b0;
            end else begin
                idx <= idx + 1'b1;
                sh  <= {sh[FRAME_LEN-2:0], 1'b0};
            end
        end
    end

    // Read data capture on rising MDC during the data field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (active && rise && rd_mode && (idx >= DATA_IDX)) begin
            rd_data <= {rd_data[DATA_W-2:0], mdi};
        end
    end
endmodule

// File: rtl/mdio_regs.sv
// Register block: command and data words, busy flag and frame launch.
// Assumes a single-cycle write strobe. Both words are locked while busy.
// go is a one-cycle pulse in the cycle after a command write that sets busy.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BUS_W  = 32,
    parameter int PHY_W  = 5,
    parameter int REG_W  = 5,
    parameter int DATA_W = 16,
    parameter int DIV_W  = 4,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h98,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h94
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_capture,
    output logic              busy,
    output logic              go,
    output logic [PHY_W-1:0]  phy_q,
    output logic [REG_W-1:0]  reg_q,
    output logic              wr_q,
    output logic [DIV_W-1:0]  div_q,
    output logic [DATA_W-1:0] data_q,
    output logic [BUS_W-1:0]  cmd_word
);
    logic pre_q;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata;

    // Stored command fields placed at their bus positions (busy excluded)
    always_comb begin
        cmd_word = '0;
        cmd_word[CMD_REG_LSB +: REG_W] = reg_q;
        cmd_word[CMD_PHY_LSB +: PHY_W] = phy_q;
        cmd_word[CMD_WR_BIT]           = wr_q;
        cmd_word[CMD_PRE_BIT]          = pre_q;
        cmd_word[CMD_DIV_LSB +: DIV_W] = div_q;
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CMD_ADDR) begin
            bus_rdata = cmd_word;
            bus_rdata[CMD_BUSY_BIT] = busy;
        end else if (bus_addr == DATA_ADDR) begin
            bus_rdata[DATA_W-1:0] = data_q;
        end
    end

    // Register writes, busy set/clear and read-data load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            go     <= 1'b0;
            phy_q  <= '0;
            reg_q  <= '0;
            wr_q   <= 1'b0;
            pre_q  <= 1'b0;
            div_q  <= '0;
            data_q <= '0;
        end else begin
            go <= 1'b0;
            if (done) begin
                busy <= 1'b0;
                if (!wr_q) begin
                    data_q <= rd_capture;
                end
            end else if (bus_wr && !busy) begin
                if (bus_addr == CMD_ADDR) begin
                    reg_q <= bus_wdata[CMD_REG_LSB +: REG_W];
                    phy_q <= bus_wdata[CMD_PHY_LSB +: PHY_W];
                    wr_q  <= bus_wdata[CMD_WR_BIT];
                    pre_q <= bus_wdata[CMD_PRE_BIT];
                    div_q <= bus_wdata[CMD_DIV_LSB +: DIV_W];
                    if (bus_wdata[CMD_BUSY_BIT]) begin
                        busy <= 1'b1;
                        go   <= 1'b1;
                    end
                end else if (bus_addr == DATA_ADDR) begin
                    data_q <= bus_wdata[DATA_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
// Top: register-driven clause-22 management frame master.
// Assembles the frame from the stored command, runs the clock divider and
// the serialiser, and hands read data back to the register block.
// Assumes an external pad combines mdio_o/mdio_oe and returns mdio_i.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int PHY_W   = 5,
    parameter int REG_W   = 5,
    parameter int DATA_W  = 16,
    parameter int DIV_W   = 4,
    parameter int PRE_LEN = 32,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h98,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h94
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int BUS_W     = 32;
    localparam int TA_POS    = PRE_LEN + 4 + PHY_W + REG_W;
    localparam int FRAME_LEN = TA_POS + 2 + DATA_W;

    logic                 busy_w;
    logic                 go;
    logic [PHY_W-1:0]     phy_q;
    logic [REG_W-1:0]     reg_q;
    logic                 wr_q;
    logic [DIV_W-1:0]     div_q;
    logic [DATA_W-1:0]    data_q;
    logic [BUS_W-1:0]     cmd_word_w;
    logic [FRAME_LEN-1:0] frame;
    logic                 active;
    logic                 done;
    logic                 rise;
    logic                 fall;
    logic [DATA_W-1:0]    rd_capture;

    // Frame assembly from the stored command and data word
    always_comb begin
        frame = {{PRE_LEN{1'b1}}, FRM_START,
                 (wr_q ? FRM_OP_WR : FRM_OP_RD),
                 phy_q, reg_q, FRM_TA_WR,
                 (wr_q ? data_q : {DATA_W{1'b1}})};
    end

    mdio_regs #(
        .ADDR_W(ADDR_W), .BUS_W(BUS_W), .PHY_W(PHY_W), .REG_W(REG_W),
        .DATA_W(DATA_W), .DIV_W(DIV_W),
        .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done(done), .rd_capture(rd_capture),
        .busy(busy_w), .go(go),
        .phy_q(phy_q), .reg_q(reg_q), .wr_q(wr_q),
        .div_q(div_q), .data_q(data_q), .cmd_word(cmd_word_w)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(active), .div(div_q),
        .mdc(mdc), .rise(rise), .fall(fall)
    );

    mdio_shifter #(
        .FRAME_LEN(FRAME_LEN), .DATA_W(DATA_W), .TA_POS(TA_POS)
    ) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start(go), .is_read(!wr_q), .frame(frame),
        .rise(rise), .fall(fall), .mdi(mdio_i),
        .mdo(mdio_o), .oe(mdio_oe),
        .active(active), .done(done), .rd_data(rd_capture)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Checker for mdio_master: pin protocol and register lock rules.
module mdio_master_chk #(
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic [BUS_W-1:0] cmd_word
);
    // R8
    oe_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);

    // R4
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R7
    mdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> ($fell(mdc) || $rose(mdio_oe)));

    // R3
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!mdio_oe && !mdc));

    // R9
    cmd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cmd_word));
endmodule

bind mdio_master mdio_master_chk #(.BUS_W(32)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy_w), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .cmd_word(cmd_word_w)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;
    localparam logic [7:0] CMD_A  = 8'h98;
    localparam logic [7:0] DATA_A = 8'h94;
    localparam int NVEC = 6;
    // {write, phy[4:0], reg[4:0], data[15:0], div[3:0]}
    localparam logic [30:0] VEC [NVEC] = '{
        {1'b1, 5'h01, 5'h00, 16'h1234, 4'h0},
        {1'b0, 5'h1F, 5'h1F, 16'hA5C3, 4'h1},
        {1'b1, 5'h10, 5'h01, 16'hFFFF, 4'h2},
        {1'b0, 5'h01, 5'h02, 16'h8001, 4'h0},
        {1'b1, 5'h00, 5'h1F, 16'h0000, 4'hA},
        {1'b0, 5'h15, 5'h0A, 16'h7E81, 4'h3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int nchk = 0, nfail = 0, wd = 0;
    int cyc = 0, last_rise = 0, rise_cnt = 0, fall_cnt = 0, per_err = 0, exp_period = 2;
    logic        mdc_prev = 1'b0;
    logic [63:0] cap_mdo, cap_oe;
    logic [15:0] phy_val = '0;

    mdio_master dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // PHY model: records MDIO on rising MDC, returns read data after falling MDC
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mdc && !mdc_prev) begin
            if (rise_cnt < 64) begin
                cap_mdo[63-rise_cnt] = mdio_o;
                cap_oe[63-rise_cnt]  = mdio_oe;
            end
            if (rise_cnt > 0 && (cyc - last_rise) != exp_period) per_err = per_err + 1;
            last_rise = cyc;
            rise_cnt  = rise_cnt + 1;
        end
        if (!mdc && mdc_prev) fall_cnt = fall_cnt + 1;
        mdc_prev = mdc;
        mdio_i = (fall_cnt >= 48 && fall_cnt < 64) ? phy_val[63-fall_cnt] : 1'b1;
    end

    // Watchdog
    always @(posedge clk) begin
        wd = wd + 1;
        if (wd == WD_LIMIT) begin
            nchk = nchk + 1;
            nfail = nfail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", wd, WD_LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk = nchk + 1;
        if (!ok) begin
            nfail = nfail + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        #1;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic clear_model(input int div);
        rise_cnt = 0; fall_cnt = 0; per_err = 0;
        exp_period = 2 * (div + 1);
        cap_mdo = '0; cap_oe = '0;
    endtask

    task automatic wait_idle();
        logic [31:0] r;
        for (int i = 0; i < 5000; i++) begin
            bus_read(CMD_A, r);
            if (!r[17]) return;
        end
        check(1'b0, "R3 busy never cleared", 64'(r), 64'h0);
    endtask

    function automatic logic [31:0] mk_cmd(input logic w, input logic [4:0] p,
                                           input logic [4:0] r, input logic [3:0] dv,
                                           input logic go);
        return (32'(dv) << 20) | (32'(go) << 17) | (32'(w) << 16) | (32'(p) << 8) | 32'(r);
    endfunction

    function automatic logic [63:0] exp_frame(input logic w, input logic [4:0] p,
                                              input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r, 2'b10, d};
    endfunction

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        bus_read(CMD_A, rd);  check(rd == 0, "R1 command after reset", 64'(rd), 0);
        bus_read(DATA_A, rd); check(rd == 0, "R1 data after reset", 64'(rd), 0);
        check(!mdc && !mdio_oe, "R1 pins after reset", {62'b0, mdc, mdio_oe}, 0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            logic        w;
            logic [4:0]  p, r;
            logic [15:0] d;
            logic [3:0]  dv;
            {w, p, r, d, dv} = VEC[v];
            if (w) bus_write(DATA_A, {16'hCAFE, d});
            phy_val = d;
            @(negedge clk); #1;
            clear_model(int'(dv));
            bus_write(CMD_A, mk_cmd(w, p, r, dv, 1'b1));
            bus_read(CMD_A, rd);
            check(rd[17], "R3 busy set after start", 64'(rd), 64'(32'h20000));
            wait_idle();
            check(rise_cnt == 64, "R3 frame length in MDC periods", 64'(rise_cnt), 64);
            check(per_err == 0, "R4 MDC period", 64'(per_err), 0);
            check(!mdio_oe && !mdc, "R8 line released after frame", {62'b0, mdc, mdio_oe}, 0);
            bus_read(CMD_A, rd);
            check(rd == mk_cmd(w, p, r, dv, 1'b0), "R2 command readback", 64'(rd), 64'(mk_cmd(w, p, r, dv, 1'b0)));
            if (w) begin
                check(cap_mdo == exp_frame(1'b1, p, r, d), "R5 write frame bits", cap_mdo, exp_frame(1'b1, p, r, d));
                check(cap_oe == '1, "R5 enable during write", cap_oe, '1);
            end else begin
                check(cap_mdo[63:18] == exp_frame(1'b0, p, r, d) >> 18, "R6 read frame header",
                      64'(cap_mdo[63:18]), exp_frame(1'b0, p, r, d) >> 18);
                check(cap_oe == {{46{1'b1}}, 18'b0}, "R6 enable released from turnaround",
                      cap_oe, {{46{1'b1}}, 18'b0});
                bus_read(DATA_A, rd);
                check(rd == 32'(d), "R6 read data captured", 64'(rd), 64'(d));
            end
        end

        // R10: command with busy clear stores fields and starts nothing
        clear_model(0);
        bus_write(CMD_A, 32'hFFFD_FFFF);
        repeat (50) @(posedge clk);
        check(rise_cnt == 0 && !mdc, "R10 no frame without busy", 64'(rise_cnt), 0);
        bus_read(CMD_A, rd);
        check(rd == 32'h00F5_1F1F, "R2 field layout readback", 64'(rd), 64'h00F5_1F1F);

        // R2: data word width
        bus_write(DATA_A, 32'hDEAD_BEEF);
        bus_read(DATA_A, rd);
        check(rd == 32'h0000_BEEF, "R2 data readback", 64'(rd), 64'h0000_BEEF);

        // R9: writes while busy are ignored
        bus_write(DATA_A, 32'h0000_0F0F);
        phy_val = 16'h0000;
        @(negedge clk); #1;
        clear_model(0);
        bus_write(CMD_A, mk_cmd(1'b1, 5'h03, 5'h04, 4'h0, 1'b1));
        repeat (10) @(posedge clk);
        bus_write(CMD_A, mk_cmd(1'b0, 5'h1C, 5'h1B, 4'h5, 1'b1));
        bus_write(DATA_A, 32'h0000_1111);
        wait_idle();
        check(cap_mdo == exp_frame(1'b1, 5'h03, 5'h04, 16'h0F0F), "R9 frame unaffected by writes while busy",
              cap_mdo, exp_frame(1'b1, 5'h03, 5'h04, 16'h0F0F));
        check(per_err == 0, "R9 divider unaffected", 64'(per_err), 0);
        bus_read(CMD_A, rd);
        check(rd == mk_cmd(1'b1, 5'h03, 5'h04, 4'h0, 1'b0), "R9 command kept", 64'(rd),
              64'(mk_cmd(1'b1, 5'h03, 5'h04, 4'h0, 1'b0)));
        bus_read(DATA_A, rd);
        check(rd == 32'h0F0F, "R9 data kept", 64'(rd), 64'h0F0F);

        // R1: reset in the middle of a frame returns to idle
        clear_model(2);
        bus_write(CMD_A, mk_cmd(1'b0, 5'h02, 5'h02, 4'h2, 1'b1));
        repeat (40) @(posedge clk);
        #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        bus_read(CMD_A, rd);
        check(rd == 0 && !mdc && !mdio_oe, "R1 reset mid-frame", 64'(rd), 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule